// File: doc/BRIEF.md
# Channel Output Guard

This block is the output-side controller of an isolated eight-channel switch. It sits between the command words recovered from an isolated serial link and the channel drivers. Each link transfer arrives as a one-cycle strobe. A valid strobe carries an 8-bit command word. A reject strobe marks a transfer that failed its integrity check. The block holds the most recent valid word and drives it onto the channel enables, but only while nothing forces the channels off.

Four kinds of condition force the channels off. The first is a run of consecutive rejected transfers. The second is an active-low disable input. The third is an input side that has not yet reported a stable state. The fourth is an undervoltage flag from the output supply. Recovery depends on the cause:

- Undervoltage and a not-ready input side are plain gates. When they clear, the held word returns by itself.
- A link-fault lockout holds the channels off until a valid word is accepted.
- A disable clears the held word and holds the channels off until a valid word is accepted.

A two-bit cause output reports why the channels are currently forced off.

Top module: `chan_guard`

## Requirements
- R1: After reset, all channel enables are 0, the cause output reads 0 (none), and the consecutive-reject count is zero.
- R2: A valid strobe is accepted when the disable input is high, the ready flag is high and the undervoltage flag is low. One cycle after an accepted strobe, the channel enables equal the command word: bit i drives channel i, and 1 means on.
- R3: On the fourth consecutive accepted-condition reject, all channel enables go to 0 one cycle later, and the cause output reads 1 (link fault).
- R4: An accepted valid strobe resets the reject count to zero. If a valid strobe and a reject strobe arrive in the same cycle, the valid strobe wins.
- R5: The reject count saturates at its threshold, so further rejects keep the channels off. The next accepted valid word turns the channels back on with that word, and the cause output returns to 0.
- R6: While the disable input is low, all channel enables are 0 in the same cycle, without waiting for a clock edge, and the cause output reads 2 (disable).
- R7: The disable clears the held word and the reject count. Valid strobes that arrive while the disable is low are ignored. After the disable returns high, the channels stay off and the cause output stays 2 until a new valid word is accepted.
- R8: While the ready flag is low, all channel enables are 0, the cause output reads 3, and link strobes are ignored. When the flag returns high, the previously held word drives the channels again.
- R9: While the undervoltage flag is high, all channel enables are 0, the cause output reads 3, and link strobes (valid and reject) are ignored. When the flag clears, the last held word is reapplied without any new transfer.
- R10: If a link-fault lockout is pending when the undervoltage flag clears, the channels stay off and the cause output reads 1.
- R11: The cause output follows a fixed priority: disable (2) first, then undervoltage or not-ready (3), then link fault (1), then none (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 8 | Command word recovered from the link |
| cmd_valid | input | 1 | One-cycle strobe: cmd_word is valid |
| cmd_reject | input | 1 | One-cycle strobe: a link transfer was rejected |
| dis_n | input | 1 | Active-low global disable, already synchronized |
| side_ready | input | 1 | High once the input-side domain reports a stable state |
| supply_uv | input | 1 | High while the output supply is in undervoltage |
| ch_en | output | 8 | Channel enables, one bit per channel |
| off_cause | output | 2 | Lockout cause: 0 none, 1 link fault, 2 disable, 3 supply/not ready |

## Verification
Some behaviours are checked by assertions on every clock edge:

- The channel enables are zero while the disable is low, while undervoltage is present or the input side is not ready, and while a link lockout is reported.
- The reject count never exceeds its threshold.
- The count is zero after any clearing event.

Other behaviours depend on history and are shown only by the bench's scenarios:

- whether the held word returns after undervoltage, and whether it stays off after a disable;
- that strobes arriving during a gate are ignored;
- the exact count at which the lockout trips;
- the priority between overlapping causes.

The bench sweeps every command word and every reject run length from zero to six.

// File: rtl/chan_guard_pkg.sv
package chan_guard_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_LINK = 2'd1,
    CAUSE_DIS  = 2'd2,
    CAUSE_PWR  = 2'd3
  } off_cause_e;
endpackage

// File: rtl/cg_reject_ctr.sv
module cg_reject_ctr #(
  parameter int LIMIT = 4,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic tripped
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != CW'(LIMIT)));
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tripped = (cnt_q == CW'(LIMIT));

  // R5: the count saturates at the threshold
  assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));
  // R4: a clearing event leaves the count at zero
  assert_cnt_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/cg_cmd_hold.sv
module cg_cmd_hold #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NCH-1:0] word,
  input  logic           dis_act,
  output logic [NCH-1:0] held,
  output logic           dis_lock
);
  logic [NCH-1:0] held_d;
  logic           held_en, lock_d, lock_en;

  always_comb begin
    held_en = load | dis_act;
    held_d  = dis_act ? '0 : word;
    lock_en = load | dis_act;
    lock_d  = dis_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (held_en) held <= held_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dis_lock <= 1'b0;
    else if (lock_en) dis_lock <= lock_d;
  end

  // R7: a disable leaves the held word cleared and the lock set
  assert_dis_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_act |=> (held == '0 && dis_lock));
endmodule

// File: rtl/cg_gate.sv
module cg_gate
  import chan_guard_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] held,
  input  logic           dis_n,
  input  logic           dis_lock,
  input  logic           pwr_bad,
  input  logic           link_lock,
  output logic [NCH-1:0] ch_en,
  output off_cause_e     cause
);
  logic blocked;

  always_comb begin
    if (!dis_n || dis_lock) cause = CAUSE_DIS;
    else if (pwr_bad)       cause = CAUSE_PWR;
    else if (link_lock)     cause = CAUSE_LINK;
    else                    cause = CAUSE_NONE;
    blocked = !dis_n | dis_lock | pwr_bad | link_lock;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_en[i] = held[i] & ~blocked;
  end
endmodule

// File: rtl/chan_guard.sv
module chan_guard
  import chan_guard_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int REJ_LIMIT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cmd_word,
  input  logic           cmd_valid,
  input  logic           cmd_reject,
  input  logic           dis_n,
  input  logic           side_ready,
  input  logic           supply_uv,
  output logic [NCH-1:0] ch_en,
  output logic [1:0]     off_cause
);
  logic           pwr_bad, link_ok, accept, rej_cnt, link_lock, dis_lock;
  logic [NCH-1:0] held;
  off_cause_e     cause;

  assign pwr_bad = ~side_ready | supply_uv;
  assign link_ok = dis_n & ~pwr_bad;
  assign accept  = link_ok & cmd_valid;
  assign rej_cnt = link_ok & cmd_reject & ~cmd_valid;

  cg_reject_ctr #(.LIMIT(REJ_LIMIT)) ctr_i (
    .clk(clk), .rst_n(rst_n), .clr(accept | ~dis_n), .inc(rej_cnt),
    .tripped(link_lock)
  );

  cg_cmd_hold #(.NCH(NCH)) hold_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .word(cmd_word),
    .dis_act(~dis_n), .held(held), .dis_lock(dis_lock)
  );

  cg_gate #(.NCH(NCH)) gate_i (
    .held(held), .dis_n(dis_n), .dis_lock(dis_lock), .pwr_bad(pwr_bad),
    .link_lock(link_lock), .ch_en(ch_en), .cause(cause)
  );

  assign off_cause = cause;

  // R6: disable forces every channel off
  assert_dis_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n |-> (ch_en == '0));
  // R9: a supply or readiness problem forces every channel off
  assert_pwr_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_uv || !side_ready) |-> (ch_en == '0));
  // R3: a reported link lockout means no channel is on
  assert_link_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (off_cause == 2'd1) |-> (ch_en == '0));
  // R2: an accepted word appears on the channels when no lock is pending
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $stable(dis_n)) |=> (!link_ok || ch_en == $past(cmd_word)));
endmodule

// File: tb/chan_guard_tb_top.sv
module chan_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cmd_word;
  logic       cmd_valid, cmd_reject, dis_n, side_ready, supply_uv;
  logic [7:0] ch_en;
  logic [1:0] off_cause;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chan_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .cmd_reject(cmd_reject), .dis_n(dis_n), .side_ready(side_ready),
    .supply_uv(supply_uv), .ch_en(ch_en), .off_cause(off_cause)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(string req, logic [7:0] exp_ch, logic [1:0] exp_cause);
    check(req, ch_en, exp_ch);
    check(req, {6'd0, off_cause}, {6'd0, exp_cause});
  endtask

  task automatic send_valid(logic [7:0] w);
    cmd_word = w; cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic send_reject(int n);
    for (int i = 0; i < n; i++) begin
      cmd_reject = 1'b1;
      step();
      cmd_reject = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_word = '0; cmd_valid = 0; cmd_reject = 0;
    dis_n = 1'b1; side_ready = 1'b1; supply_uv = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check_state("R1 reset", 8'h00, 2'd0);

    // R2: every command word reaches the channels
    for (int w = 0; w < 256; w++) begin
      send_valid(8'(w));
      check_state("R2 word sweep", 8'(w), 2'd0);
    end

    // R3/R5: reject run lengths 0..6, then recovery by a valid word
    for (int k = 0; k <= 6; k++) begin
      send_valid(8'hA5);
      send_reject(k);
      check_state(k >= 4 ? "R3 lockout" : "R3 below threshold",
                  k >= 4 ? 8'h00 : 8'hA5, k >= 4 ? 2'd1 : 2'd0);
      send_valid(8'h3C);
      check_state("R5 recovery", 8'h3C, 2'd0);
    end

    // R4: a valid word resets the count; valid beats reject
    send_reject(3);
    send_valid(8'h0F);
    send_reject(3);
    check_state("R4 count reset", 8'h0F, 2'd0);
    cmd_reject = 1'b1;
    send_valid(8'hF0);
    cmd_reject = 1'b0;
    check_state("R4 valid wins", 8'hF0, 2'd0);
    send_reject(3);
    check_state("R4 after tie", 8'hF0, 2'd0);

    // R6/R7: disable
    send_valid(8'h5A);
    dis_n = 1'b0;
    #1;
    check_state("R6 immediate off", 8'h00, 2'd2);
    send_valid(8'h77);
    check_state("R7 ignored while low", 8'h00, 2'd2);
    dis_n = 1'b1;
    step();
    check_state("R7 held off after release", 8'h00, 2'd2);
    send_valid(8'h55);
    check_state("R7 fresh word", 8'h55, 2'd0);

    // R8: input side not ready
    side_ready = 1'b0;
    #1;
    check_state("R8 not ready off", 8'h00, 2'd3);
    send_valid(8'h11);
    side_ready = 1'b1;
    #1;
    check_state("R8 held word back", 8'h55, 2'd0);

    // R9: undervoltage, strobes ignored, word reapplied
    supply_uv = 1'b1;
    #1;
    check_state("R9 uv off", 8'h00, 2'd3);
    send_valid(8'h22);
    send_reject(4);
    supply_uv = 1'b0;
    #1;
    check_state("R9 reapply", 8'h55, 2'd0);

    // R10/R11: lockout pending across undervoltage, priority
    send_reject(4);
    check_state("R10 lockout", 8'h00, 2'd1);
    supply_uv = 1'b1;
    #1;
    check_state("R11 uv over link", 8'h00, 2'd3);
    supply_uv = 1'b0;
    step();
    check_state("R10 still locked", 8'h00, 2'd1);
    supply_uv = 1'b1;
    dis_n = 1'b0;
    #1;
    check_state("R11 dis over uv", 8'h00, 2'd2);
    step();
    supply_uv = 1'b0;
    dis_n = 1'b1;
    step();
    check_state("R11 dis lock held", 8'h00, 2'd2);
    send_valid(8'h99);
    check_state("R5 final word", 8'h99, 2'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule